// File: doc/BRIEF.md
# Banked GPIO Register File

This block holds the software-visible state of a 128-pin general-purpose I/O controller. The pins are grouped into four banks of 32. Pin `i` belongs to bank `i >> 5` and sits at bit `i % 32` of that bank, which is also bit `i` of the 128-bit pin buses. A plain 32-bit register bus reaches, per bank, a direction word, a write-one-to-set port, a write-one-to-clear port, a level word and two alternate-function words. Writes take effect at the clock edge. Read data is combinational from the address in the cycle `bus_re` is high.

Each pin's driven value is its output latch gated by its direction bit. The level word gives software a single view of every pin: driven pins report the latch and input pins report the synchronized level on `pin_in`. The register map is irregular. Banks 0 to 2 sit at consecutive words, and bank 3 is placed 0x100 higher. The rising-enable, falling-enable and edge-status registers belong to a companion block. For those, this block only decodes the address, raises a per-register strobe and returns the companion's read data.

Top module: `gpio_bank_regs`

## Requirements
- R1: After reset, every direction, output-latch and alternate-function word is zero, `pin_out` is all zero, and a level read returns `pin_in` unchanged.
- R2: A write to the set port ORs the write data into that bank's latch. The set ports for banks 0..3 are at 0x018, 0x01C, 0x020 and 0x118.
- R3: A write to the clear port clears each latch bit where the write data is 1 and leaves the other bits unchanged. The clear ports for banks 0..3 are at 0x024, 0x028, 0x02C and 0x124.
- R4: Reading a set port or a clear port returns zero.
- R5: Reading a level word (banks 0..3 at 0x000, 0x004, 0x008, 0x100) returns, bit by bit, the latch where the direction bit is 1 and `pin_in` where it is 0, using the `pin_in` value of the read cycle.
- R6: The direction words (banks 0..3 at 0x00C, 0x010, 0x014, 0x10C) are read/write. A 1 bit makes the pin an output.
- R7: `pin_out[32*b+k]` equals latch bit k of bank b ANDed with direction bit k of bank b.
- R8: The alternate-function words are plain read/write storage. Bank b's low word is at 0x054+8*b and its upper word is at 0x058+8*b.
- R9: A write to an offset at or above 0x200, or to any offset not in the map (including unaligned offsets), changes no state and no output. A read of such an offset returns zero.
- R10: `level_rd_pulse` is high in exactly those cycles where `bus_re` is high and the address is a level word.
- R11: Companion-register accesses raise exactly one bit of `edge_we` (on a write) or `edge_re` (on a read), with index 4*kind+bank. The kinds are 0 for rising enable (0x030, 0x034, 0x038, 0x130), 1 for falling enable (0x03C, 0x040, 0x044, 0x13C) and 2 for edge status (0x048, 0x04C, 0x050, 0x148). Such a read returns `edge_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 12 | Byte offset of the access |
| bus_we | input | 1 | Write enable |
| bus_re | input | 1 | Read enable |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational, zero when idle |
| edge_rdata | input | 32 | Read data from the companion edge block |
| pin_in | input | 128 | Synchronized pin levels |
| pin_out | output | 128 | Driven pin values |
| level_rd_pulse | output | 1 | High while a level word is read |
| edge_we | output | 12 | Companion write strobes, index 4*kind+bank |
| edge_re | output | 12 | Companion read strobes, index 4*kind+bank |

## Verification
A level read and a change of `pin_in` can land in the same cycle. The read must then mix the latch on output bits with the new input value on input bits, and raise the polling strobe. The bench sets a split direction on one bank and, in one cycle, drives a fresh `pin_in` value together with the level read. It then compares the returned word against the per-bit mix computed from its own model and the new input. It also confirms that `pin_out` has not moved.

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs #(
  parameter int AW = 12,
  parameter int DW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     bus_addr,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic [DW-1:0]     edge_rdata,
  input  logic [4*DW-1:0]   pin_in,
  output logic [4*DW-1:0]   pin_out,
  output logic              level_rd_pulse,
  output logic [11:0]       edge_we,
  output logic [11:0]       edge_re
);
  localparam int NB  = 4;
  localparam int WIN = 'h200;

  logic in_win;
  logic [NB-1:0] hit_lvl, hit_dir, hit_set, hit_clr, hit_rise, hit_fall, hit_stat;
  logic [NB-1:0][DW-1:0] rd_part;
  logic [DW-1:0] rd_any;

  assign in_win = bus_addr < AW'(WIN);

  for (genvar b = 0; b < NB; b++) begin : g_bank
    localparam int STEP = (b == NB-1) ? 'h100 : 4*b;
    logic [DW-1:0] dir_q, lat_q, alt_lo_q, alt_hi_q;
    logic hit_alo, hit_ahi;
    logic [DW-1:0] pin_sl;

    assign hit_lvl[b]  = in_win && bus_addr == AW'('h000 + STEP);
    assign hit_dir[b]  = in_win && bus_addr == AW'('h00C + STEP);
    assign hit_set[b]  = in_win && bus_addr == AW'('h018 + STEP);
    assign hit_clr[b]  = in_win && bus_addr == AW'('h024 + STEP);
    assign hit_rise[b] = in_win && bus_addr == AW'('h030 + STEP);
    assign hit_fall[b] = in_win && bus_addr == AW'('h03C + STEP);
    assign hit_stat[b] = in_win && bus_addr == AW'('h048 + STEP);
    assign hit_alo     = in_win && bus_addr == AW'('h054 + 8*b);
    assign hit_ahi     = in_win && bus_addr == AW'('h058 + 8*b);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        dir_q    <= '0;
        lat_q    <= '0;
        alt_lo_q <= '0;
        alt_hi_q <= '0;
      end else if (bus_we) begin
        if (hit_dir[b]) dir_q    <= bus_wdata;
        if (hit_set[b]) lat_q    <= lat_q | bus_wdata;
        if (hit_clr[b]) lat_q    <= lat_q & ~bus_wdata;
        if (hit_alo)    alt_lo_q <= bus_wdata;
        if (hit_ahi)    alt_hi_q <= bus_wdata;
      end
    end

    assign pin_sl = pin_in[b*DW +: DW];
    assign pin_out[b*DW +: DW] = lat_q & dir_q;

    assign rd_part[b] = ({DW{hit_lvl[b]}} & ((lat_q & dir_q) | (pin_sl & ~dir_q)))
                      | ({DW{hit_dir[b]}} & dir_q)
                      | ({DW{hit_alo}}    & alt_lo_q)
                      | ({DW{hit_ahi}}    & alt_hi_q)
                      | ({DW{hit_rise[b] | hit_fall[b] | hit_stat[b]}} & edge_rdata);

    assign edge_we[b]        = bus_we & hit_rise[b];
    assign edge_we[NB+b]     = bus_we & hit_fall[b];
    assign edge_we[2*NB+b]   = bus_we & hit_stat[b];
    assign edge_re[b]        = bus_re & hit_rise[b];
    assign edge_re[NB+b]     = bus_re & hit_fall[b];
    assign edge_re[2*NB+b]   = bus_re & hit_stat[b];

    a_r2_set_keeps_ones: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && hit_set[b]) |=> ((lat_q & $past(bus_wdata)) == $past(bus_wdata)));
    a_r3_clear_drops_ones: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && hit_clr[b]) |=> ((lat_q & $past(bus_wdata)) == '0));
    a_r4_write_only_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_re && (hit_set[b] || hit_clr[b])) |-> (bus_rdata == '0));
    a_r9_outside_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && !in_win) |=> $stable(pin_out[b*DW +: DW]));
  end

  always_comb begin
    rd_any = '0;
    for (int i = 0; i < NB; i++) rd_any = rd_any | rd_part[i];
  end

  assign bus_rdata      = bus_re ? rd_any : '0;
  assign level_rd_pulse = bus_re & (|hit_lvl);

  a_r10_pulse_needs_read: assert property (@(posedge clk) disable iff (!rst_n)
    level_rd_pulse |-> bus_re);
  a_r11_one_edge_write: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(edge_we));
  a_r11_one_edge_read: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(edge_re));
endmodule

// File: tb/test_gpio_bank_regs.sv
module test_gpio_bank_regs;
  localparam int CLK_PERIOD = 10;

  logic clk = 0;
  logic rst_n = 0;
  logic [11:0] bus_addr = '0;
  logic bus_we = 0, bus_re = 0;
  logic [31:0] bus_wdata = '0, edge_rdata = '0;
  logic [31:0] bus_rdata;
  logic [127:0] pin_in = '0, pin_out;
  logic level_rd_pulse;
  logic [11:0] edge_we, edge_re;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [31:0] dir_m [4];
  logic [31:0] lat_m [4];
  logic [31:0] alt_m [8];
  logic [31:0] seed = 32'h1234_5678;

  gpio_bank_regs i_gpio_bank_regs (
    .clk, .rst_n, .bus_addr, .bus_we, .bus_re, .bus_wdata, .bus_rdata,
    .edge_rdata, .pin_in, .pin_out, .level_rd_pulse, .edge_we, .edge_re
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] nxt();
    seed = seed * 32'd1664525 + 32'd1013904223;
    return seed;
  endfunction

  function automatic logic [11:0] bofs(int base, int b);
    return 12'(base + ((b == 3) ? 'h100 : 4*b));
  endfunction
  function automatic logic [11:0] lvl_a(int b); return bofs('h000, b); endfunction
  function automatic logic [11:0] dir_a(int b); return bofs('h00C, b); endfunction
  function automatic logic [11:0] set_a(int b); return bofs('h018, b); endfunction
  function automatic logic [11:0] clr_a(int b); return bofs('h024, b); endfunction
  function automatic logic [11:0] edg_a(int k, int b); return bofs('h030 + 'h0C*k, b); endfunction
  function automatic logic [11:0] alt_a(int w); return 12'('h054 + 4*w); endfunction

  function automatic bit is_mapped(logic [11:0] a);
    for (int b = 0; b < 4; b++) begin
      if (a == lvl_a(b) || a == dir_a(b) || a == set_a(b) || a == clr_a(b)) return 1;
      for (int k = 0; k < 3; k++) if (a == edg_a(k, b)) return 1;
    end
    for (int w = 0; w < 8; w++) if (a == alt_a(w)) return 1;
    return 0;
  endfunction

  function automatic logic [127:0] exp_out();
    logic [127:0] r;
    for (int b = 0; b < 4; b++) r[b*32 +: 32] = lat_m[b] & dir_m[b];
    return r;
  endfunction

  function automatic logic [31:0] exp_lvl(int b);
    return (lat_m[b] & dir_m[b]) | (pin_in[b*32 +: 32] & ~dir_m[b]);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1;
    @(negedge clk);
    bus_we = 0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d, output logic s);
    @(negedge clk);
    bus_addr = a; bus_re = 1;
    #1;
    d = bus_rdata; s = level_rd_pulse;
    #1;
    bus_re = 0;
  endtask

  task automatic check_all_state(input string req);
    logic [31:0] d;
    logic s;
    chk(pin_out == exp_out(), req, pin_out, exp_out());
    for (int b = 0; b < 4; b++) begin
      rd(dir_a(b), d, s); chk(d == dir_m[b], req, d, dir_m[b]);
      rd(lvl_a(b), d, s); chk(d == exp_lvl(b), req, d, exp_lvl(b));
    end
    for (int w = 0; w < 8; w++) begin
      rd(alt_a(w), d, s); chk(d == alt_m[w], req, d, alt_m[w]);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, v;
    logic s;
    for (int b = 0; b < 4; b++) begin dir_m[b] = '0; lat_m[b] = '0; end
    for (int w = 0; w < 8; w++) alt_m[w] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    pin_in = {nxt(), nxt(), nxt(), nxt()};

    // R1: reset state
    check_all_state("R1");

    // R2 / R3: all-output bank, set then clear
    for (int b = 0; b < 4; b++) begin
      wr(dir_a(b), '1); dir_m[b] = '1;
      v = nxt();
      wr(set_a(b), v); lat_m[b] |= v;
      rd(lvl_a(b), d, s); chk(d == lat_m[b], "R2", d, lat_m[b]);
      v = nxt();
      wr(set_a(b), v); lat_m[b] |= v;
      rd(lvl_a(b), d, s); chk(d == lat_m[b], "R2", d, lat_m[b]);
      v = nxt();
      wr(clr_a(b), v); lat_m[b] &= ~v;
      rd(lvl_a(b), d, s); chk(d == lat_m[b], "R3", d, lat_m[b]);
    end

    // R4 R5 R6 R7: mixed patterns
    for (int r = 0; r < 12; r++) begin
      for (int b = 0; b < 4; b++) begin
        v = nxt(); wr(dir_a(b), v); dir_m[b] = v;
        v = nxt(); wr(set_a(b), v); lat_m[b] |= v;
        v = nxt(); wr(clr_a(b), v); lat_m[b] &= ~v;
        pin_in = {nxt(), nxt(), nxt(), nxt()};
        chk(pin_out == exp_out(), "R7", pin_out, exp_out());
        rd(dir_a(b), d, s); chk(d == dir_m[b], "R6", d, dir_m[b]);
        rd(lvl_a(b), d, s); chk(d == exp_lvl(b), "R5", d, exp_lvl(b));
        rd(set_a(b), d, s); chk(d == 0, "R4", d, 0);
        rd(clr_a(b), d, s); chk(d == 0, "R4", d, 0);
      end
    end

    // R8: alternate-function storage
    for (int w = 0; w < 8; w++) begin
      v = nxt(); wr(alt_a(w), v); alt_m[w] = v;
    end
    for (int w = 0; w < 8; w++) begin
      rd(alt_a(w), d, s); chk(d == alt_m[w], "R8", d, alt_m[w]);
    end

    // R9: unmapped and out-of-window offsets
    for (int a = 0; a < 'h1000; a += 4) begin
      if (!is_mapped(12'(a))) begin
        wr(12'(a), '1);
        rd(12'(a), d, s); chk(d == 0, "R9", d, 0);
      end
    end
    for (int b = 0; b < 4; b++) begin
      wr(set_a(b) + 12'd1, '1);
      wr(dir_a(b) + 12'd2, '1);
    end
    check_all_state("R9");

    // R10: strobe only on level reads
    for (int b = 0; b < 4; b++) begin
      rd(lvl_a(b), d, s); chk(s == 1, "R10", s, 1);
      rd(dir_a(b), d, s); chk(s == 0, "R10", s, 0);
    end
    rd(12'h300, d, s); chk(s == 0, "R10", s, 0);

    // R11: companion strobes and read pass-through
    for (int k = 0; k < 3; k++) begin
      for (int b = 0; b < 4; b++) begin
        @(negedge clk);
        bus_addr = edg_a(k, b); bus_wdata = nxt(); bus_we = 1;
        #1;
        chk(edge_we == 12'(1 << (4*k + b)), "R11", edge_we, 12'(1 << (4*k + b)));
        chk(edge_re == 0, "R11", edge_re, 0);
        @(negedge clk);
        bus_we = 0; bus_re = 1; edge_rdata = nxt();
        #1;
        chk(edge_re == 12'(1 << (4*k + b)), "R11", edge_re, 12'(1 << (4*k + b)));
        chk(bus_rdata == edge_rdata, "R11", bus_rdata, edge_rdata);
        chk(edge_we == 0, "R11", edge_we, 0);
        #1 bus_re = 0;
      end
    end
    check_all_state("R11");

    // R5 + R10 in one cycle: pin_in moves together with a level read
    wr(dir_a(1), 32'hFFFF_0000); dir_m[1] = 32'hFFFF_0000;
    wr(set_a(1), 32'h5A5A_5A5A); lat_m[1] |= 32'h5A5A_5A5A;
    for (int r = 0; r < 4; r++) begin
      @(negedge clk);
      pin_in = {nxt(), nxt(), nxt(), nxt()};
      bus_addr = lvl_a(1); bus_re = 1;
      #1;
      chk(bus_rdata == exp_lvl(1), "R5", bus_rdata, exp_lvl(1));
      chk(level_rd_pulse == 1, "R10", level_rd_pulse, 1);
      chk(pin_out == exp_out(), "R7", pin_out, exp_out());
      #1 bus_re = 0;
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule